// File: doc/BRIEF.md
# Vector Destination Policy Merge Unit

This block assembles the value that is finally written into a vector destination register. For every element of a chunk it chooses among the freshly computed result, the previous destination contents and an all-ones fill pattern. The choice depends on where the element sits relative to the restart index and the active length, on its mask bit, and on the two policy bits. A chunk is 64 bits per lane times `LANES` lanes. The element width is chosen per operation, and an internal index counter tracks the absolute element number of each chunk.

An operation begins with a one-cycle `start` pulse while the configuration inputs (`vl`, `vstart`, `vlmax`, `sew`, policy bits, `mask_en`, `fill_ones`) are held steady. Chunks then stream in on a valid/ready input carrying the old destination data, the result data and the mask bits. Merged chunks leave on a valid/ready output together with a per-element write enable.

A chunk is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Once `out_valid` is asserted, it and the output payload stay unchanged until `out_ready` is seen high, so a stalled consumer back-pressures the producer with no loss. `done` rises after the chunk holding the last element below `vlmax` has been accepted.

Top module: `vdpm_merge_unit`

## Requirements
- R1: An element whose absolute index is below `vstart` keeps its old value and has write enable 0. This rule takes precedence over every other rule.
- R2: A tail element (index at or above `vl`) with `tail_agn`=0 keeps its old value and has write enable 0.
- R3: A tail element with `tail_agn`=1 becomes all ones with write enable 1 when `fill_ones`=1. When `fill_ones`=0 it keeps its old value with write enable 0.
- R4: A body element (vstart <= index < vl) is active when `mask_en`=0 or when its mask bit is 1. An active element takes the result value and has write enable 1.
- R5: A body element with `mask_en`=1 and mask bit 0 keeps its old value with write enable 0 when `mask_agn`=0. When `mask_agn`=1 and `fill_ones`=1 it becomes all ones with write enable 1. When `mask_agn`=1 and `fill_ones`=0 it keeps its old value with write enable 0.
- R6: `sew` codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. A chunk then holds E = 8*LANES >> sew elements. Element j occupies data bits [j*EW +: EW] and uses mask bit j and write-enable bit j. Write-enable bits j >= E are 0. The element index grows by E with each accepted chunk.
- R7: `start` sets the element index to 0 and clears `done`. `done` is 1 from the edge that accepts the chunk whose last index reaches `vlmax`-1 or beyond, and stays 1 until the next `start`.
- R8: A chunk is taken on `in_valid`&`in_ready`, and its merged result appears on the output on the following cycle. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_we` hold, and no new chunk is taken.
- R9: After reset, `out_valid` and `done` are 0, `in_ready` is 1 and the element index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new operation (index to 0) |
| vl | input | IDX_W | Active vector length |
| vstart | input | IDX_W | First element allowed to be written |
| vlmax | input | IDX_W | Element count of the full register group |
| sew | input | 2 | Element width code |
| tail_agn | input | 1 | 1 = tail agnostic, 0 = tail undisturbed |
| mask_agn | input | 1 | 1 = mask agnostic, 0 = mask undisturbed |
| fill_ones | input | 1 | Agnostic elements are filled with ones when 1 |
| mask_en | input | 1 | 1 = masked operation |
| in_valid | input | 1 | Input chunk valid |
| in_ready | output | 1 | Input chunk can be taken |
| in_old | input | 64*LANES | Old destination chunk |
| in_res | input | 64*LANES | Result chunk |
| in_mask | input | 8*LANES | Mask bits, one per element |
| out_valid | output | 1 | Merged chunk valid |
| out_ready | input | 1 | Consumer takes merged chunk |
| out_data | output | 64*LANES | Merged chunk |
| out_we | output | 8*LANES | Per-element write enable |
| done | output | 1 | Last chunk of the operation taken |

## Verification
If the index counter drifts, the fault shows up in the very next merged chunk. Elements near the `vstart` or `vl` boundaries flip between old, result and fill values, and `done` rises one chunk early or late. A wrong width decode scrambles which bytes take the result, and it also sets write-enable bits above the chunk's element count, in the same chunk. Mishandled back-pressure shows up as a changed or dropped payload during a stall, which the reference queue flags at the next output handshake.

// File: rtl/vdpm_pkg.sv
package vdpm_pkg;
  localparam int LANE_W = 64;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    K_PREFIX   = 2'd0,
    K_BODY_ON  = 2'd1,
    K_BODY_OFF = 2'd2,
    K_TAIL     = 2'd3
  } kind_e;
endpackage

// File: rtl/vdpm_idx_ctr.sv
module vdpm_idx_ctr #(
  parameter int IDX_W = 12,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  input  logic [CW-1:0]    step,
  input  logic [IDX_W-1:0] vlmax,
  output logic [IDX_W-1:0] base,
  output logic             done
);
  logic [IDX_W:0] nxt;

  assign nxt = {1'b0, base} + (IDX_W+1)'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      done <= 1'b0;
    end else if (start) begin
      base <= '0;
      done <= 1'b0;
    end else if (adv) begin
      base <= nxt[IDX_W-1:0];
      if (nxt >= {1'b0, vlmax}) done <= 1'b1;
    end
  end
endmodule

// File: rtl/vdpm_elem_class.sv
module vdpm_elem_class
  import vdpm_pkg::*;
#(
  parameter int NE    = 32,
  parameter int IDX_W = 12,
  parameter int CW    = 6
) (
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] vstart,
  input  logic [IDX_W-1:0] vl,
  input  logic [CW-1:0]    step,
  input  logic [NE-1:0]    mask,
  input  logic             mask_en,
  input  logic             tail_agn,
  input  logic             mask_agn,
  input  logic             fill_ones,
  output logic [NE-1:0]    take_res,
  output logic [NE-1:0]    fill,
  output logic [NE-1:0]    we
);
  for (genvar j = 0; j < NE; j++) begin : g_el
    logic [IDX_W:0] idx;
    logic           in_chunk;
    logic           user_on;
    logic           len_on;   // internal mask: index compared against vl
    kind_e          kind;

    always_comb begin
      idx      = {1'b0, base} + (IDX_W+1)'(j);
      in_chunk = j < int'(step);
      user_on  = !mask_en || mask[j];
      len_on   = idx < {1'b0, vl};
      if (idx < {1'b0, vstart})  kind = K_PREFIX;
      else if (!len_on)          kind = K_TAIL;
      else if (user_on)          kind = K_BODY_ON;
      else                       kind = K_BODY_OFF;
    end

    assign take_res[j] = in_chunk && (kind == K_BODY_ON);
    assign fill[j]     = in_chunk && fill_ones &&
                         (((kind == K_TAIL) && tail_agn) ||
                          ((kind == K_BODY_OFF) && mask_agn));
  end

  assign we = take_res | fill;
endmodule

// File: rtl/vdpm_byte_merge.sv
module vdpm_byte_merge #(
  parameter int NB = 32
) (
  input  logic [1:0]      sew,
  input  logic [NB*8-1:0] old_d,
  input  logic [NB*8-1:0] res_d,
  input  logic [NB-1:0]   take_res,
  input  logic [NB-1:0]   fill,
  output logic [NB*8-1:0] out_d
);
  localparam int EIW = (NB > 1) ? $clog2(NB) : 1;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [EIW-1:0] eid;
    assign eid = EIW'(b) >> sew;
    assign out_d[b*8 +: 8] = take_res[eid] ? res_d[b*8 +: 8] :
                             fill[eid]     ? 8'hFF :
                                             old_d[b*8 +: 8];
  end
endmodule

// File: rtl/vdpm_merge_unit.sv
module vdpm_merge_unit
  import vdpm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDX_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        vl,
  input  logic [IDX_W-1:0]        vstart,
  input  logic [IDX_W-1:0]        vlmax,
  input  logic [1:0]              sew,
  input  logic                    tail_agn,
  input  logic                    mask_agn,
  input  logic                    fill_ones,
  input  logic                    mask_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*64-1:0]     in_old,
  input  logic [LANES*64-1:0]     in_res,
  input  logic [LANES*8-1:0]      in_mask,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*64-1:0]     out_data,
  output logic [LANES*8-1:0]      out_we,
  output logic                    done
);
  localparam int DW = LANES * LANE_W;
  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0]    step;
  logic [IDX_W-1:0] base;
  logic             accept;
  logic [NB-1:0]    take_res, fill, we_c;
  logic [DW-1:0]    merged;

  assign step     = CW'(NB >> sew);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vdpm_idx_ctr #(.IDX_W(IDX_W), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(accept),
    .step(step), .vlmax(vlmax), .base(base), .done(done)
  );

  vdpm_elem_class #(.NE(NB), .IDX_W(IDX_W), .CW(CW)) u_cls (
    .base(base), .vstart(vstart), .vl(vl), .step(step), .mask(in_mask),
    .mask_en(mask_en), .tail_agn(tail_agn), .mask_agn(mask_agn),
    .fill_ones(fill_ones), .take_res(take_res), .fill(fill), .we(we_c)
  );

  vdpm_byte_merge #(.NB(NB)) u_mrg (
    .sew(sew), .old_d(in_old), .res_d(in_res),
    .take_res(take_res), .fill(fill), .out_d(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= merged;
      out_we    <= we_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vdpm_merge_chk.sv
module vdpm_merge_chk #(
  parameter int NB = 32,
  parameter int DW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    sew,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [NB-1:0] out_we,
  input logic          done
);
  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R8
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_we)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R6
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_we >> (NB >> sew)) == '0));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !done));
endmodule

bind vdpm_merge_unit vdpm_merge_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sew(sew), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_we(out_we), .done(done)
);

// File: tb/vdpm_merge_unit_tb_top.sv
module vdpm_merge_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int LANES = 4;
  localparam int IDX_W = 12;
  localparam int DW    = LANES * 64;
  localparam int NB    = LANES * 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] vl = '0, vstart = '0, vlmax = '0;
  logic [1:0] sew = 2'd0;
  logic tail_agn = 0, mask_agn = 0, fill_ones = 0, mask_en = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, done;
  logic [DW-1:0] in_old = '0, in_res = '0, out_data;
  logic [NB-1:0] in_mask = '0, out_we;

  vdpm_merge_unit #(.LANES(LANES), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .vstart(vstart),
    .vlmax(vlmax), .sew(sew), .tail_agn(tail_agn), .mask_agn(mask_agn),
    .fill_ones(fill_ones), .mask_en(mask_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_old(in_old), .in_res(in_res), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] q_d[$];
  logic [NB-1:0] q_we[$];
  logic [NB-1:0] q_m[$];
  int            q_base[$];
  int            m_base;
  logic          exp_done;

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    report();
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int idx, int j, logic mbit);
    int ep = NB >> sew;
    if (j >= ep) return "R6";
    if (idx < int'(vstart)) return "R1";
    if (idx >= int'(vl)) return tail_agn ? "R3" : "R2";
    if (!mask_en || mbit) return "R4";
    return "R5";
  endfunction

  // Behavioural expectation of one chunk
  task automatic expect_chunk(input int base, input logic [DW-1:0] old,
                              input logic [DW-1:0] res, input logic [NB-1:0] m,
                              output logic [DW-1:0] d, output logic [NB-1:0] we);
    int ep = NB >> sew;
    int bpe = 1 << sew;
    d = old;
    we = '0;
    for (int j = 0; j < ep; j++) begin
      int idx = base + j;
      logic wr_res = 0, wr_one = 0;
      if (idx < int'(vstart)) begin
      end else if (idx >= int'(vl)) begin
        wr_one = tail_agn && fill_ones;
      end else if (!mask_en || m[j]) begin
        wr_res = 1;
      end else begin
        wr_one = mask_agn && fill_ones;
      end
      for (int k = 0; k < bpe; k++) begin
        if (wr_res) d[(j*bpe+k)*8 +: 8] = res[(j*bpe+k)*8 +: 8];
        if (wr_one) d[(j*bpe+k)*8 +: 8] = 8'hFF;
      end
      we[j] = wr_res || wr_one;
    end
  endtask

  task automatic compare_out();
    logic [DW-1:0] ed = q_d.pop_front();
    logic [NB-1:0] ew = q_we.pop_front();
    logic [NB-1:0] em = q_m.pop_front();
    int            b  = q_base.pop_front();
    int            bpe = 1 << sew;
    string         r = "R8";
    if (q_d.size() < 0) r = "R8";
    if (out_data !== ed || out_we !== ew) begin
      for (int j = NB - 1; j >= 0; j--) begin
        if (out_data[j*8 +: 8] !== ed[j*8 +: 8])
          r = req_of(b + j / bpe, j / bpe, em[j / bpe]);
      end
      for (int j = NB - 1; j >= 0; j--) begin
        if (out_we[j] !== ew[j]) r = req_of(b + j, j, em[j]);
      end
    end
    check(out_data === ed, r, "data", out_data, ed);
    check(out_we === ew, r, "we", DW'(out_we), DW'(ew));
  endtask

  task automatic run_op(input int ready_pct);
    int ep  = NB >> sew;
    int nch = (int'(vlmax) + ep - 1) / ep;
    int sent = 0;
    logic acc;
    @(posedge clk); #1 start = 1; in_valid = 0;
    @(negedge clk); m_base = 0; exp_done = 0;
    @(posedge clk); #1 start = 0;
    forever begin
      @(negedge clk);
      check(done === exp_done, "R7", "done", DW'(done), DW'(exp_done));
      if (out_valid && out_ready) begin
        if (q_d.size() == 0) check(1'b0, "R8", "spurious output", DW'(1), DW'(0));
        else compare_out();
      end
      acc = in_valid && in_ready;
      if (acc) begin
        logic [DW-1:0] d;
        logic [NB-1:0] w;
        expect_chunk(m_base, in_old, in_res, in_mask, d, w);
        q_d.push_back(d); q_we.push_back(w); q_m.push_back(in_mask);
        q_base.push_back(m_base);
        m_base += ep;
        sent++;
        if (m_base >= int'(vlmax)) exp_done = 1;
      end
      if (sent == nch && q_d.size() == 0) break;
      @(posedge clk); #1;
      if (acc || !in_valid) begin
        if (sent < nch) begin
          in_valid = 1;
          for (int k = 0; k < DW / 32; k++) begin
            in_old[k*32 +: 32] = $urandom;
            in_res[k*32 +: 32] = $urandom;
          end
          in_mask = NB'($urandom);
        end else in_valid = 0;
      end
      out_ready = ($urandom % 100) < ready_pct;
    end
    @(posedge clk); #1 out_ready = 0;
    @(negedge clk);
    check(done === 1'b1, "R7", "done after last chunk", DW'(done), DW'(1));
  endtask

  task automatic cfg(input int s, input int l, input int st, input int mx,
                     input logic ta, input logic ma, input logic f1, input logic me);
    sew = 2'(s); vl = IDX_W'(l); vstart = IDX_W'(st); vlmax = IDX_W'(mx);
    tail_agn = ta; mask_agn = ma; fill_ones = f1; mask_en = me;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9", "out_valid", DW'(out_valid), DW'(0));
    check(done === 1'b0, "R9", "done", DW'(done), DW'(0));
    check(in_ready === 1'b1, "R9", "in_ready", DW'(in_ready), DW'(1));
    rst_n = 1;
    // R1 R2 R5: 8-bit, undisturbed policies, masked
    cfg(0, 50, 3, 64, 0, 0, 0, 1); run_op(70);
    // R3 R5: 16-bit, both agnostic with fill, masked
    cfg(1, 20, 0, 40, 1, 1, 1, 1); run_op(50);
    // R3 R4: 32-bit, agnostic without fill, unmasked
    cfg(2, 13, 5, 24, 1, 1, 0, 0); run_op(100);
    // R2 R5: 64-bit, tail undisturbed, mask agnostic fill
    cfg(3, 7, 2, 16, 0, 1, 1, 1); run_op(40);
    // R3: vl of zero, everything is tail
    cfg(1, 0, 0, 32, 1, 0, 1, 1); run_op(60);
    // R1: vstart beyond vl
    cfg(2, 6, 10, 16, 1, 1, 1, 1); run_op(80);
    // R6 R7: single chunk, full length
    cfg(0, 32, 0, 32, 0, 0, 0, 0); run_op(100);
    // R8: heavy back-pressure
    cfg(0, 100, 7, 128, 1, 0, 1, 1); run_op(15);
    report();
  end
endmodule